// File: doc/BRIEF.md
# Shared-Bus Master with Multiplexed Address and Data

This block is the initiator side of a simple shared bus on which one set of wires carries first an address and then the data of a transfer. A user-side port hands it read and write commands through a valid/ready handshake. The block queues these commands, raises a bus request, waits for the grant, and spends one setup cycle after the grant. It then drives the address until the slave answers ready, and performs a data phase of exactly one cycle on the cycle after that answer.

On a write, the block drives the write data during the data phase. On a read, it releases the bus, captures the slave's value at the end of the data phase and returns it to the user with a one-cycle valid pulse. The bus is non-preemptive. While more commands are waiting, the request stays high and the next address follows the data phase straight away, with no new arbitration. The request drops during the final data phase. Bus driving is modelled as a value plus an output-enable, so no tri-state logic appears inside the block.

Top module: `mux_bus_master`

## Requirements
- R1: During reset and on the first cycle after it, bus_req, bus_oe and rsp_valid are low and cmd_ready is high.
- R2: A command accepted while the block is idle (req low, no transfer) makes bus_req high in the cycle right after the accepting clock edge.
- R3: While bus_req is high and no transfer is running, a grant sampled high at a clock edge is followed by one setup cycle, and the address phase starts on the second cycle after that edge. While the grant is low the block keeps waiting with bus_req high.
- R4: In the address phase bus_oe is high and bus_out holds the command's address, unchanged, until bus_rdy is sampled high.
- R5: The cycle after bus_rdy is sampled high in the address phase is the data phase, and it lasts exactly one cycle. A write drives its data on bus_out with bus_oe high. A read holds bus_oe low.
- R6: For a read, bus_in is sampled at the clock edge that ends the data phase. Its value appears on rsp_rdata with rsp_valid high for exactly one cycle, starting the cycle after the data phase. Writes produce no rsp_valid.
- R7: If another command is already queued when the data phase starts, bus_req stays high through the data phase and the next address phase begins on the very next cycle, with no setup cycle.
- R8: If no further command is queued when the data phase starts, bus_req is low during that data phase and the block returns to idle with bus_oe low.
- R9: Commands reach the bus in the order they were accepted. The queue holds QDEPTH commands (2 by default). When it is full, cmd_ready is low and a command offered on cmd_valid is not taken.
- R10: Once the address phase has begun, dropping bus_gnt has no effect: the transfer runs to the end of its data phase.
- R11: bus_rw is 1 for a write and 0 for a read throughout the address and data phases of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | User command offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | BUS_W | Transfer address |
| cmd_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | BUS_W | Captured read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_rdy | input | 1 | Slave ready, ends the address phase |
| bus_rw | output | 1 | 1 = write transfer, 0 = read |
| bus_out | output | BUS_W | Value driven on the shared bus |
| bus_oe | output | 1 | Drive enable for bus_out |
| bus_in | input | BUS_W | Value sampled from the shared bus |

## Verification
The hardest situation to reach is a chain of back-to-back transfers where the third command is only accepted once the first data phase has freed a queue slot. It must still land before the second address phase ends, so that the request stays high across every data phase. The stimulus gets there by offering commands on consecutive cycles while the bench slave holds ready back for several cycles. The bench then measures that each new address appears exactly one cycle after the previous data phase. A second hard case is a full queue held against a grant that never comes. There the bench keeps an extra command on the user port and confirms that it never reaches the bus.

// File: rtl/mbm_pkg.sv
// Shared types for the multiplexed-bus master.
// Assumes: nothing beyond IEEE 1800-2017.
package mbm_pkg;

    // Control states of the bus master; encoding fixed for observers.
    typedef enum logic [2:0] {
        ST_IDLE = 3'b000,
        ST_WAIT = 3'b001,
        ST_INIT = 3'b010,
        ST_ADDR = 3'b011,
        ST_DATA = 3'b100
    } mbm_state_e;

endpackage

// File: rtl/mbm_cmd_queue.sv
// Small in-order command queue between the user port and the bus side.
// Assumes: push only when not full, pop only when not empty (caller guards).
module mbm_cmd_queue #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    count_next
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy after this cycle's push and pop.
    always_comb begin
        count_next = count + CW'(push) - CW'(pop);
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count_next;
        end
    end

    // Entry storage, written at the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && wr_ptr == PW'(i)) slot[i] <= din;
        end
    end

    // Oldest entry is presented continuously.
    always_comb begin
        head = slot[rd_ptr];
    end

endmodule

// File: rtl/mbm_ctrl_fsm.sv
// Bus-side control: request line and the five-state transfer sequence.
// Assumes: cnt_next is the queue occupancy after this cycle, and the
// queue head is popped in every data phase.
module mbm_ctrl_fsm
    import mbm_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt,
    input  logic          rdy,
    input  logic [CW-1:0] cnt_next,
    output mbm_state_e    state,
    output logic          req
);

    mbm_state_e state_d;
    logic       req_d;

    // Next state from the present request, grant and ready.
    always_comb begin
        if (!req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_d = gnt ? ST_INIT : ST_WAIT;
                ST_INIT:          state_d = ST_ADDR;
                ST_ADDR:          state_d = rdy ? ST_DATA : ST_ADDR;
                ST_DATA:          state_d = ST_ADDR;
                default:          state_d = ST_IDLE;
            endcase
        end
    end

    // Request for next cycle: in a data phase only if work remains behind it.
    always_comb begin
        if (state_d == ST_DATA) req_d = (cnt_next > CW'(1));
        else                    req_d = (cnt_next != '0);
    end

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            req   <= 1'b0;
        end else begin
            state <= state_d;
            req   <= req_d;
        end
    end

endmodule

// File: rtl/mbm_bus_datapath.sv
// Drives the shared bus from the queue head and captures read data.
// Assumes: head fields stay constant from address phase through data phase.
module mbm_bus_datapath
    import mbm_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mbm_state_e       state,
    input  logic             head_write,
    input  logic [BUS_W-1:0] head_addr,
    input  logic [BUS_W-1:0] head_wdata,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             bus_rw,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);

    // Bus value, enable and direction per phase.
    always_comb begin
        bus_out = '0;
        bus_oe  = 1'b0;
        bus_rw  = 1'b0;
        unique case (state)
            ST_ADDR: begin
                bus_out = head_addr;
                bus_oe  = 1'b1;
                bus_rw  = head_write;
            end
            ST_DATA: begin
                bus_out = head_write ? head_wdata : '0;
                bus_oe  = head_write;
                bus_rw  = head_write;
            end
            default: ;
        endcase
    end

    // Read capture at the end of a read data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_DATA) && !head_write;
            if ((state == ST_DATA) && !head_write) rsp_rdata <= bus_in;
        end
    end

endmodule

// File: rtl/mux_bus_master.sv
// Master for a non-preemptive shared bus whose address and data share wires.
// Accepts user commands, arbitrates, runs address and data phases, returns
// read data. Assumes an external arbiter and slave; bus is value plus enable.
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int QDEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [BUS_W-1:0] cmd_addr,
    input  logic [BUS_W-1:0] cmd_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic             bus_rdy,
    output logic             bus_rw,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    input  logic [BUS_W-1:0] bus_in
);

    localparam int EW = 1 + 2 * BUS_W;
    localparam int CW = $clog2(QDEPTH + 1);

    mbm_state_e    state;
    logic [CW-1:0] q_count;
    logic [CW-1:0] q_count_next;
    logic [EW-1:0] q_head;
    logic          q_push;
    logic          q_pop;

    // User handshake and queue control.
    always_comb begin
        cmd_ready = (q_count != CW'(QDEPTH));
        q_push    = cmd_valid && cmd_ready;
        q_pop     = (state == ST_DATA);
    end

    mbm_cmd_queue #(
        .WIDTH (EW),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .pop        (q_pop),
        .din        ({cmd_write, cmd_addr, cmd_wdata}),
        .head       (q_head),
        .count      (q_count),
        .count_next (q_count_next)
    );

    mbm_ctrl_fsm #(
        .CW (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .gnt      (bus_gnt),
        .rdy      (bus_rdy),
        .cnt_next (q_count_next),
        .state    (state),
        .req      (bus_req)
    );

    mbm_bus_datapath #(
        .BUS_W (BUS_W)
    ) u_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .head_write (q_head[EW-1]),
        .head_addr  (q_head[2*BUS_W-1:BUS_W]),
        .head_wdata (q_head[BUS_W-1:0]),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .bus_rw     (bus_rw),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/mbm_checker.sv
// Protocol checker for mux_bus_master, attached by bind.
// Assumes: state is the master's control state, q_empty its queue status.
module mbm_checker
    import mbm_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input mbm_state_e       state,
    input logic             q_empty,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_rdy,
    input logic             bus_oe,
    input logic [BUS_W-1:0] bus_out,
    input logic             rsp_valid
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !bus_req && !bus_oe && !rsp_valid));

    assert_grant_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_WAIT) && bus_req && bus_gnt) |=> state == ST_INIT);

    assert_wait_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_WAIT) && bus_req && !bus_gnt) |=> state == ST_WAIT);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && !bus_rdy) |=> (state == ST_ADDR && bus_oe && $stable(bus_out)));

    assert_data_after_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && bus_rdy) |=> state == ST_DATA);

    assert_data_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |=> state != ST_DATA);

    assert_oe_in_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (state == ST_ADDR || state == ST_DATA));

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bus_req) |=> state == ST_ADDR);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !bus_req) |=> (state == ST_IDLE && !bus_oe));

    assert_data_has_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DATA |-> !q_empty);

    assert_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ADDR |-> bus_req);

endmodule

bind mux_bus_master mbm_checker #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .q_empty   (q_count == '0),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_rdy   (bus_rdy),
    .bus_oe    (bus_oe),
    .bus_out   (bus_out),
    .rsp_valid (rsp_valid)
);

// File: tb/mux_bus_master_tb.sv
// Scoreboard bench: driver task queues expected bus operations and read
// results; a negedge model plays arbiter and slave and compares.
module mux_bus_master_tb;

    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid, cmd_ready, cmd_write;
    logic [BW-1:0] cmd_addr, cmd_wdata;
    logic          rsp_valid;
    logic [BW-1:0] rsp_rdata;
    logic          bus_req, bus_gnt, bus_rdy, bus_rw, bus_oe;
    logic [BW-1:0] bus_out, bus_in;

    always #4 clk = ~clk;

    mux_bus_master #(.BUS_W(BW), .QDEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rdy(bus_rdy),
        .bus_rw(bus_rw), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
    );

    typedef struct {
        bit            wr;
        logic [BW-1:0] addr;
        logic [BW-1:0] wdata;
    } op_t;

    op_t           bus_q[$];
    logic [BW-1:0] rsp_q[$];
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 0;

    // knobs set by the test sequence
    int gnt_delay = 0;
    int rdy_delay = 0;
    bit gnt_hold_off = 0;
    bit drop_gnt = 0;

    // observations made by the bus model
    int  cyc = 0;
    int  ph = 0;
    int  rcnt = 0;
    int  wcnt = 0;
    int  gnt_rise_cyc = 0;
    int  last_addr_cyc = 0;
    int  last_data_cyc = 0;
    int  last_gap = 0;
    int  n_addr = 0;
    int  n_data = 0;
    int  n_data_req = 0;
    bit  last_req_in_data = 0;
    bit  rsp_due = 0;
    op_t cur;

    function automatic logic [BW-1:0] rd_val(input logic [BW-1:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Arbiter, slave and response monitor, all at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt = 1'b0; bus_rdy = 1'b0; bus_in = '1;
            ph = 0; wcnt = 0; rsp_due = 0;
        end else begin
            cyc++;
            if (rsp_due) begin
                chk(rsp_valid == 1'b1, "R6 rsp_valid pulse", rsp_valid, 1);
                if (rsp_q.size() != 0) begin
                    logic [BW-1:0] e;
                    e = rsp_q.pop_front();
                    chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
                end else chk(0, "R6 no expected read", rsp_rdata, 0);
                rsp_due = 0;
            end else if (rsp_valid) begin
                chk(0, "R6 unexpected rsp_valid", 1, 0);
            end
            if (!bus_req) begin
                bus_gnt = 1'b0; wcnt = 0;
            end else if (!bus_gnt && !gnt_hold_off && ph == 0 && !bus_oe) begin
                if (wcnt >= gnt_delay) begin
                    bus_gnt = 1'b1; gnt_rise_cyc = cyc;
                end else wcnt++;
            end
            if (ph == 2) begin
                n_data++; last_data_cyc = cyc; last_req_in_data = bus_req;
                if (bus_req) n_data_req++;
                bus_rdy = 1'b0;
                chk(bus_rw == cur.wr, "R11 rw in data phase", bus_rw, cur.wr);
                if (cur.wr) begin
                    chk(bus_oe == 1'b1, "R5 write drives bus", bus_oe, 1);
                    chk(bus_out == cur.wdata, "R5 write data", bus_out, cur.wdata);
                end else begin
                    chk(bus_oe == 1'b0, "R5 read releases bus", bus_oe, 0);
                    bus_in = rd_val(cur.addr);
                    rsp_due = 1;
                end
                ph = 0;
            end else begin
                bus_in = '1;
                if (ph == 0 && bus_oe) begin
                    last_gap = cyc - last_data_cyc; last_addr_cyc = cyc; n_addr++;
                    if (bus_q.size() == 0) begin
                        chk(0, "R9 unexpected address", bus_out, 0);
                        cur = '{wr: bus_rw, addr: bus_out, wdata: '0};
                    end else begin
                        cur = bus_q.pop_front();
                        chk(bus_out == cur.addr, "R9 address order", bus_out, cur.addr);
                        chk(bus_rw == cur.wr, "R11 rw in address phase", bus_rw, cur.wr);
                    end
                    ph = 1; rcnt = 0;
                end
                if (ph == 1) begin
                    chk(bus_oe && bus_out == cur.addr, "R4 address held", bus_out, cur.addr);
                    if (drop_gnt) bus_gnt = 1'b0;
                    if (rcnt >= rdy_delay) begin
                        bus_rdy = 1'b1; ph = 2;
                    end else begin
                        bus_rdy = 1'b0; rcnt++;
                    end
                end
            end
        end
    end

    // Driver: offers one command, records expectations when it is taken.
    task automatic send(input bit wr, input logic [BW-1:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        while (!cmd_ready) @(negedge clk);
        bus_q.push_back('{wr: wr, addr: a, wdata: d});
        if (!wr) rsp_q.push_back(rd_val(a));
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((bus_q.size() != 0 || rsp_q.size() != 0 || bus_req || bus_oe || ph != 0 || rsp_due) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) chk(0, "R9 transfers did not drain", t, 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base_addr, base_data, base_req;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R1 req low in reset", bus_req, 0);
        chk(bus_oe == 1'b0, "R1 oe low in reset", bus_oe, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid low in reset", rsp_valid, 0);
        chk(cmd_ready == 1'b1, "R1 ready in reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0 && bus_oe == 1'b0, "R1 idle after reset", {bus_req, bus_oe}, 0);

        // single read, immediate grant, two wait cycles before ready
        gnt_delay = 0; rdy_delay = 2;
        send(0, 16'h1234, '0);
        @(negedge clk);
        chk(bus_req == 1'b1, "R2 req after accept", bus_req, 1);
        wait_idle();
        chk(last_addr_cyc - gnt_rise_cyc == 2, "R3 address two cycles after grant", last_addr_cyc - gnt_rise_cyc, 2);
        chk(last_req_in_data == 1'b0, "R8 req low in last data phase", last_req_in_data, 0);
        chk(bus_req == 1'b0 && bus_oe == 1'b0, "R8 back to idle", {bus_req, bus_oe}, 0);

        // single write through the waiting path, ready on first address cycle
        gnt_delay = 3; rdy_delay = 0;
        send(1, 16'h00A7, 16'hBEEF);
        wait_idle();
        chk(last_addr_cyc - gnt_rise_cyc == 2, "R3 address after delayed grant", last_addr_cyc - gnt_rise_cyc, 2);

        // three chained commands, third taken after the first slot frees
        gnt_delay = 1; rdy_delay = 3;
        base_req = n_data_req; base_data = n_data;
        send(1, 16'h0310, 16'h1111);
        send(0, 16'h0320, '0);
        send(1, 16'h0330, 16'h3333);
        wait_idle();
        chk(n_data - base_data == 3, "R7 three data phases", n_data - base_data, 3);
        chk(n_data_req - base_req == 2, "R7 req held through chained data", n_data_req - base_req, 2);
        chk(last_gap == 1, "R7 next address right after data", last_gap, 1);

        // full queue: extra offer must not be taken
        gnt_hold_off = 1; gnt_delay = 0; rdy_delay = 1;
        base_addr = n_addr;
        send(0, 16'h0440, '0);
        send(1, 16'h0450, 16'h5555);
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R9 ready low when full", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0BAD; cmd_wdata = 16'hDEAD;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b0, "R9 still full while offered", cmd_ready, 0);
        #1 cmd_valid = 1'b0;
        gnt_hold_off = 0;
        wait_idle();
        chk(n_addr - base_addr == 2, "R9 offered command not taken", n_addr - base_addr, 2);

        // grant withdrawn during the address phase
        drop_gnt = 1; rdy_delay = 4;
        base_data = n_data;
        send(0, 16'h0560, '0);
        wait_idle();
        drop_gnt = 0;
        chk(n_data - base_data == 1, "R10 transfer completes without grant", n_data - base_data, 1);

        // mixed stream with varying delays
        for (int i = 0; i < 10; i++) begin
            gnt_delay = i % 3; rdy_delay = (i * 5) % 4;
            send(i[0], 16'h0A00 + 16'(i * 17), 16'h7000 + 16'(i * 3));
        end
        wait_idle();
        chk(bus_q.size() == 0 && rsp_q.size() == 0, "R9 all commands in order", bus_q.size() + rsp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule